// File: doc/BRIEF.md
# Conversion and Power-Mode Sequencer

This block sits between the serial slave of a multirange data-acquisition converter and its analog core. It takes decoded bus events from the slave: a control-field strobe, a power-field strobe, an address-match-with-write pulse, a received-bit strobe and a STOP pulse. From these it drives the track/hold switch, the channel and range selects, and the enables for the converter core, the reference buffer and the bandgap. It also runs a successive-approximation loop against a comparator bit and returns a formatted result with a one-cycle strobe.

A control word whose marker bit is set opens acquisition at once. The following STOP closes acquisition and starts conversion. A requested software power mode is held back until that conversion finishes. Leaving a software power mode takes an address-match write followed by one more received bit. The active-low shutdown pin overrides everything asynchronously and aborts any conversion.

Top module: `conv_power_seq`

## Requirements
- R1: After reset, th_track is 0, chan_sel, range_sel, bipolar_sel, result and result_stb are 0, and core_en, refbuf_en and bgap_en are all 1.
- R2: While idle or tracking, in normal mode and out of shutdown, a ctl_stb with ctl_marker=1 sets th_track and loads chan_sel, range_sel and bipolar_sel from the strobe's fields at the same clock edge.
- R3: A ctl_stb with ctl_marker=0 leaves th_track and every select unchanged and does not lead to a conversion.
- R4: ev_stop while tracking clears th_track and starts a conversion. ev_stop while not tracking produces no result.
- R5: The loop decides one bit per CONV_DIV clocks, from MSB to LSB, and keeps a trial bit when cmp_in is 1 (input at or above dac_code). result_stb rises for one cycle exactly NBITS*CONV_DIV clock edges after the edge that sampled ev_stop, and result changes only at that edge.
- R6: With bipolar_sel=0 the result is the straight binary SAR code. With bipolar_sel=1 it is the SAR code with its MSB inverted (two's complement).
- R7: The power field is decoded as follows: pd_mode[1]=0 means normal (core, buffer and bandgap on), 2'b10 means standby (core off, buffer and bandgap on), and 2'b11 means full power-down (only bandgap on). The field is captured only while tracking, and the new mode takes effect at the edge that raises result_stb. Until then the enables stay unchanged.
- R8: shdn_n low immediately, without waiting for a clock, forces th_track=0, core_en=0, refbuf_en=0 and bgap_en=1. It aborts any running conversion without a result and blocks new acquisitions. Normal enables return two clock edges after shdn_n rises.
- R9: In standby or full power-down, an ev_addr_wr pulse arms a wake-up, and the next ev_bit returns the block to normal mode. ev_bit without a prior arm has no effect, and ev_stop clears the arm.
- R10: ctl_stb is ignored during a conversion and while the block is in a software power-down mode.
- R11: If shutdown falls in the cycle of the last SAR decision, no result is produced and result keeps its previous value. A later conversion still completes correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| shdn_n | input | 1 | Asynchronous active-low hardware shutdown |
| ev_addr_wr | input | 1 | Pulse: address matched with write bit |
| ev_bit | input | 1 | Pulse: one bus bit received |
| ev_stop | input | 1 | Pulse: bus STOP condition |
| ctl_stb | input | 1 | Pulse: control fields valid |
| ctl_marker | input | 1 | Marker bit of the control word |
| ctl_chan | input | CHW (3) | Requested input channel |
| ctl_range | input | 1 | Requested full-scale range |
| ctl_bipolar | input | 1 | Requested bipolar coding |
| pd_stb | input | 1 | Pulse: power field valid |
| pd_mode | input | 2 | Power field {PD1, PD0} |
| cmp_in | input | 1 | Comparator: 1 when input is at or above dac_code |
| th_track | output | 1 | Track/hold in tracking position |
| chan_sel | output | CHW (3) | Selected channel |
| range_sel | output | 1 | Selected range |
| bipolar_sel | output | 1 | Selected bipolar mode |
| dac_code | output | NBITS (12) | Trial code for the comparator DAC |
| core_en | output | 1 | Converter core enable |
| refbuf_en | output | 1 | Reference buffer enable |
| bgap_en | output | 1 | Bandgap enable |
| result | output | NBITS (12) | Formatted conversion result |
| result_stb | output | 1 | One-cycle pulse: result updated |

## Verification
The final successive-approximation decision and a hardware shutdown can land on the same clock edge. Completion would load the result and apply the pending power mode, while shutdown must cancel both. The bench counts clock edges from the STOP that starts a conversion and drops shdn_n half a cycle before the edge of the last decision. It then requires that no strobe appears, that the result keeps the previous conversion's value, and that the next conversion after release delivers its exact expected code.

// File: rtl/cps_pkg.sv
package cps_pkg;

  typedef enum logic [1:0] {
    PM_NORMAL  = 2'd0,
    PM_STANDBY = 2'd1,
    PM_FULL    = 2'd2
  } pmode_t;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_TRACK = 2'd1,
    SQ_CONV  = 2'd2
  } sq_t;

  // {PD1,PD0}: PD1 low -> normal, 10 -> standby, 11 -> full power-down
  function automatic pmode_t pd_decode(input logic [1:0] pd);
    pmode_t m;
    if (!pd[1])      m = PM_NORMAL;
    else if (!pd[0]) m = PM_STANDBY;
    else             m = PM_FULL;
    return m;
  endfunction

endpackage

// File: rtl/cps_sync.sv
// Level synchronizer: output drops asynchronously with clr_n, rises after STAGES edges.
module cps_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic clr_n,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/cps_tick.sv
// Conversion-clock divider: one tick every DIV clocks while run is high.
module cps_tick #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    tick  = run && (cnt_q == CW'(DIV - 1));
    cnt_d = cnt_q;
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/cps_sar.sv
// Successive-approximation register: one decision per tick, MSB first.
module cps_sar #(
  parameter int NBITS = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             abort,
  input  logic             tick,
  input  logic             cmp,
  output logic [NBITS-1:0] trial,
  output logic [NBITS-1:0] code,
  output logic             done
);
  localparam int IW = (NBITS > 1) ? $clog2(NBITS) : 1;

  logic [NBITS-1:0] trial_q, trial_d;
  logic [IW-1:0]    idx_q, idx_d;
  logic             act_q, act_d;
  logic [NBITS-1:0] cur_bit, next_bit;

  always_comb begin
    cur_bit  = NBITS'(1) << idx_q;
    next_bit = (idx_q != '0) ? (NBITS'(1) << (idx_q - IW'(1))) : '0;
    code     = cmp ? trial_q : (trial_q & ~cur_bit);
    done     = act_q && tick && (idx_q == '0);

    trial_d = trial_q;
    idx_d   = idx_q;
    act_d   = act_q;
    if (abort) begin
      act_d = 1'b0;
    end else if (start) begin
      trial_d = NBITS'(1) << (NBITS - 1);
      idx_d   = IW'(NBITS - 1);
      act_d   = 1'b1;
    end else if (act_q && tick) begin
      trial_d = code | next_bit;
      if (idx_q == '0) act_d = 1'b0;
      else             idx_d = idx_q - IW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trial_q <= '0;
      idx_q   <= '0;
      act_q   <= 1'b0;
    end else begin
      trial_q <= trial_d;
      idx_q   <= idx_d;
      act_q   <= act_d;
    end
  end

  assign trial = trial_q;
endmodule

// File: rtl/cps_power.sv
// Power-mode register, deferred request, wake-up arm and enable decode.
module cps_power
  import cps_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hw_off,
  input  logic       pd_stb,
  input  logic [1:0] pd_mode,
  input  logic       cap_ok,
  input  logic       conv_done,
  input  logic       ev_addr_wr,
  input  logic       ev_bit,
  input  logic       ev_stop,
  output pmode_t     mode,
  output logic       core_en,
  output logic       refbuf_en,
  output logic       bgap_en
);
  pmode_t mode_q, mode_d, pend_q, pend_d;
  logic   arm_q, arm_d;

  always_comb begin
    pend_d = pend_q;
    mode_d = mode_q;
    arm_d  = arm_q;
    if (pd_stb && cap_ok) pend_d = pd_decode(pd_mode);
    if (hw_off) begin
      arm_d = 1'b0;
    end else if (conv_done) begin
      mode_d = pend_q;
    end else if (mode_q != PM_NORMAL) begin
      if (arm_q && ev_bit) begin
        mode_d = PM_NORMAL;
        arm_d  = 1'b0;
      end else if (ev_addr_wr) begin
        arm_d = 1'b1;
      end else if (ev_stop) begin
        arm_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= PM_NORMAL;
      pend_q <= PM_NORMAL;
      arm_q  <= 1'b0;
    end else begin
      mode_q <= mode_d;
      pend_q <= pend_d;
      arm_q  <= arm_d;
    end
  end

  always_comb begin
    bgap_en = 1'b1;
    if (hw_off) begin
      core_en   = 1'b0;
      refbuf_en = 1'b0;
    end else begin
      unique case (mode_q)
        PM_NORMAL:  begin core_en = 1'b1; refbuf_en = 1'b1; end
        PM_STANDBY: begin core_en = 1'b0; refbuf_en = 1'b1; end
        default:    begin core_en = 1'b0; refbuf_en = 1'b0; end
      endcase
    end
  end

  assign mode = mode_q;
endmodule

// File: rtl/conv_power_seq.sv
module conv_power_seq
  import cps_pkg::*;
#(
  parameter int NBITS       = 12,
  parameter int NCHAN       = 8,
  parameter int CONV_DIV    = 4,
  parameter int SYNC_STAGES = 2,
  localparam int CHW        = (NCHAN > 1) ? $clog2(NCHAN) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shdn_n,
  input  logic             ev_addr_wr,
  input  logic             ev_bit,
  input  logic             ev_stop,
  input  logic             ctl_stb,
  input  logic             ctl_marker,
  input  logic [CHW-1:0]   ctl_chan,
  input  logic             ctl_range,
  input  logic             ctl_bipolar,
  input  logic             pd_stb,
  input  logic [1:0]       pd_mode,
  input  logic             cmp_in,
  output logic             th_track,
  output logic [CHW-1:0]   chan_sel,
  output logic             range_sel,
  output logic             bipolar_sel,
  output logic [NBITS-1:0] dac_code,
  output logic             core_en,
  output logic             refbuf_en,
  output logic             bgap_en,
  output logic [NBITS-1:0] result,
  output logic             result_stb
);
  logic rst_sync_n, shdn_ok, hw_off;

  cps_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk(clk), .clr_n(rst_n), .q(rst_sync_n)
  );
  cps_sync #(.STAGES(SYNC_STAGES)) u_shdn_sync (
    .clk(clk), .clr_n(shdn_n), .q(shdn_ok)
  );
  assign hw_off = ~shdn_ok;

  sq_t              st_q, st_d;
  logic [CHW-1:0]   chan_q, chan_d;
  logic             rng_q, rng_d, bip_q, bip_d;
  logic [NBITS-1:0] res_q, res_d;
  logic             stb_q, stb_d;
  logic             accept, sar_start, tick, sar_done, done_g;
  logic [NBITS-1:0] sar_code, fmt_code;
  pmode_t           mode;

  cps_tick #(.DIV(CONV_DIV)) u_tick (
    .clk(clk), .rst_n(rst_sync_n),
    .run((st_q == SQ_CONV) && !hw_off), .tick(tick)
  );

  cps_sar #(.NBITS(NBITS)) u_sar (
    .clk(clk), .rst_n(rst_sync_n), .start(sar_start), .abort(hw_off),
    .tick(tick), .cmp(cmp_in), .trial(dac_code), .code(sar_code),
    .done(sar_done)
  );

  assign done_g = sar_done && !hw_off && (st_q == SQ_CONV);

  cps_power u_pwr (
    .clk(clk), .rst_n(rst_sync_n), .hw_off(hw_off),
    .pd_stb(pd_stb), .pd_mode(pd_mode), .cap_ok(st_q == SQ_TRACK),
    .conv_done(done_g), .ev_addr_wr(ev_addr_wr), .ev_bit(ev_bit),
    .ev_stop(ev_stop), .mode(mode), .core_en(core_en),
    .refbuf_en(refbuf_en), .bgap_en(bgap_en)
  );

  generate
    if (NBITS > 1) begin : g_fmt_wide
      assign fmt_code = bip_q ? {~sar_code[NBITS-1], sar_code[NBITS-2:0]} : sar_code;
    end else begin : g_fmt_one
      assign fmt_code = bip_q ? ~sar_code : sar_code;
    end
  endgenerate

  always_comb begin
    accept = ctl_stb && ctl_marker && !hw_off && (mode == PM_NORMAL) &&
             ((st_q == SQ_IDLE) || ((st_q == SQ_TRACK) && !ev_stop));
    st_d      = st_q;
    sar_start = 1'b0;
    if (hw_off) begin
      st_d = SQ_IDLE;
    end else begin
      unique case (st_q)
        SQ_IDLE:  if (accept) st_d = SQ_TRACK;
        SQ_TRACK: if (ev_stop) begin
                    st_d      = SQ_CONV;
                    sar_start = 1'b1;
                  end
        SQ_CONV:  if (done_g) st_d = SQ_IDLE;
        default:  st_d = SQ_IDLE;
      endcase
    end

    chan_d = chan_q;
    rng_d  = rng_q;
    bip_d  = bip_q;
    if (accept) begin
      chan_d = ctl_chan;
      rng_d  = ctl_range;
      bip_d  = ctl_bipolar;
    end

    res_d = res_q;
    stb_d = done_g;
    if (done_g) res_d = fmt_code;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      st_q   <= SQ_IDLE;
      chan_q <= '0;
      rng_q  <= 1'b0;
      bip_q  <= 1'b0;
      res_q  <= '0;
      stb_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      chan_q <= chan_d;
      rng_q  <= rng_d;
      bip_q  <= bip_d;
      res_q  <= res_d;
      stb_q  <= stb_d;
    end
  end

  assign th_track    = (st_q == SQ_TRACK) && !hw_off;
  assign chan_sel    = chan_q;
  assign range_sel   = rng_q;
  assign bipolar_sel = bip_q;
  assign result      = res_q;
  assign result_stb  = stb_q;
endmodule

// File: rtl/conv_power_seq_chk.sv
module conv_power_seq_chk #(
  parameter int NBITS = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             shdn_n,
  input logic             ctl_stb,
  input logic             ctl_marker,
  input logic             th_track,
  input logic             core_en,
  input logic             refbuf_en,
  input logic             bgap_en,
  input logic [NBITS-1:0] result,
  input logic             result_stb
);
  assert_track_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(th_track) |-> $past(ctl_stb && ctl_marker));

  assert_shdn_forces_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !shdn_n |-> (!th_track && !core_en && !refbuf_en && bgap_en));

  assert_no_result_in_shdn_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!shdn_n && $past(!shdn_n)) |-> !result_stb);

  assert_enable_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bgap_en && (!core_en || refbuf_en));

  assert_track_needs_power_R10: assert property (@(posedge clk) disable iff (!rst_n)
    th_track |-> core_en);

  assert_result_on_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(result) |-> result_stb);

  assert_strobe_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    result_stb |=> !result_stb);
endmodule

bind conv_power_seq conv_power_seq_chk #(.NBITS(NBITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .shdn_n(shdn_n), .ctl_stb(ctl_stb),
  .ctl_marker(ctl_marker), .th_track(th_track), .core_en(core_en),
  .refbuf_en(refbuf_en), .bgap_en(bgap_en), .result(result),
  .result_stb(result_stb)
);

// File: tb/conv_power_seq_bench.sv
module conv_power_seq_bench;
  localparam int NB  = 12;
  localparam int DIV = 4;
  localparam int LAT = NB * DIV;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, shdn_n, ev_addr_wr, ev_bit, ev_stop, ctl_stb, ctl_marker;
  logic [2:0] ctl_chan;
  logic ctl_range, ctl_bipolar, pd_stb, cmp_in;
  logic [1:0] pd_mode;
  logic th_track, range_sel, bipolar_sel, core_en, refbuf_en, bgap_en, result_stb;
  logic [2:0] chan_sel;
  logic [NB-1:0] dac_code, result;
  logic [NB-1:0] vin_r;

  assign cmp_in = (vin_r >= dac_code);

  conv_power_seq u_conv_power_seq (
    .clk(clk), .rst_n(rst_n), .shdn_n(shdn_n), .ev_addr_wr(ev_addr_wr),
    .ev_bit(ev_bit), .ev_stop(ev_stop), .ctl_stb(ctl_stb),
    .ctl_marker(ctl_marker), .ctl_chan(ctl_chan), .ctl_range(ctl_range),
    .ctl_bipolar(ctl_bipolar), .pd_stb(pd_stb), .pd_mode(pd_mode),
    .cmp_in(cmp_in), .th_track(th_track), .chan_sel(chan_sel),
    .range_sel(range_sel), .bipolar_sel(bipolar_sel), .dac_code(dac_code),
    .core_en(core_en), .refbuf_en(refbuf_en), .bgap_en(bgap_en),
    .result(result), .result_stb(result_stb)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  logic [NB-1:0] exp_q[$];
  logic [NB-1:0] last_res = '0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // Monitor: pops the scoreboard on every result strobe
  always @(negedge clk) begin
    logic [NB-1:0] e;
    if (rst_n && result_stb) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R4 unexpected result", int'(result), 0);
      end else begin
        e = exp_q.pop_front();
        chk(result == e, "R6 result coding", int'(result), int'(e));
      end
    end
  end

  function automatic int en3();
    return {29'd0, core_en, refbuf_en, bgap_en};
  endfunction

  function automatic int mode_en(input logic [1:0] pd);
    if (!pd[1]) return 7;
    if (!pd[0]) return 3;
    return 1;
  endfunction

  task automatic pulse_ctl(input bit mk, input logic [2:0] ch, input bit rng, input bit bip);
    @(negedge clk);
    ctl_stb = 1'b1; ctl_marker = mk; ctl_chan = ch; ctl_range = rng; ctl_bipolar = bip;
    @(negedge clk);
    ctl_stb = 1'b0;
  endtask

  task automatic pulse_pd(input logic [1:0] pd);
    @(negedge clk); pd_stb = 1'b1; pd_mode = pd;
    @(negedge clk); pd_stb = 1'b0;
  endtask

  task automatic pulse_stop();
    @(negedge clk); ev_stop = 1'b1;
    @(negedge clk); ev_stop = 1'b0;
  endtask

  task automatic pulse_addr();
    @(negedge clk); ev_addr_wr = 1'b1;
    @(negedge clk); ev_addr_wr = 1'b0;
  endtask

  task automatic pulse_bit();
    @(negedge clk); ev_bit = 1'b1;
    @(negedge clk); ev_bit = 1'b0;
  endtask

  // Driver: one complete write-and-convert transaction
  task automatic run_conv(input logic [2:0] ch, input bit rng, input bit bip,
                          input logic [1:0] pd, input logic [NB-1:0] vin,
                          input int pre_en);
    logic [NB-1:0] e;
    int n;
    vin_r = vin;
    pulse_ctl(1'b1, ch, rng, bip);
    chk(th_track == 1'b1, "R2 track opens", int'(th_track), 1);
    chk({chan_sel, range_sel, bipolar_sel} == {ch, rng, bip}, "R2 selects",
        int'({chan_sel, range_sel, bipolar_sel}), int'({ch, rng, bip}));
    pulse_pd(pd);
    e = bip ? (vin ^ 12'h800) : vin;
    exp_q.push_back(e);
    last_res = e;
    pulse_stop();
    chk(th_track == 1'b0, "R4 track closes on stop", int'(th_track), 0);
    chk(en3() == pre_en, "R7 mode deferred during conversion", en3(), pre_en);
    n = 0;
    while (!result_stb && n < 1000) begin
      @(negedge clk);
      n++;
    end
    chk(n == LAT, "R5 conversion latency", n, LAT);
    chk(en3() == mode_en(pd), "R7 mode after conversion", en3(), mode_en(pd));
    @(negedge clk);
  endtask

  initial begin
    #(8 * 150000);
    chk(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    rst_n = 1'b0; shdn_n = 1'b1; ev_addr_wr = 1'b0; ev_bit = 1'b0; ev_stop = 1'b0;
    ctl_stb = 1'b0; ctl_marker = 1'b0; ctl_chan = '0; ctl_range = 1'b0;
    ctl_bipolar = 1'b0; pd_stb = 1'b0; pd_mode = 2'b00; vin_r = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk({th_track, chan_sel, range_sel, bipolar_sel} == 6'd0, "R1 selects",
        int'({th_track, chan_sel, range_sel, bipolar_sel}), 0);
    chk(result == '0 && !result_stb, "R1 result", int'(result), 0);
    chk(en3() == 7, "R1 enables", en3(), 7);

    // R3 marker clear: ignored, no conversion
    pulse_ctl(1'b0, 3'd5, 1'b1, 1'b1);
    chk({th_track, chan_sel, range_sel, bipolar_sel} == 6'd0, "R3 marker ignored",
        int'({th_track, chan_sel, range_sel, bipolar_sel}), 0);
    pulse_stop();
    repeat (LAT + 10) @(negedge clk);
    chk(result == '0, "R4 stop without track", int'(result), 0);

    // R5/R6 unipolar and bipolar patterns
    run_conv(3'd3, 1'b1, 1'b0, 2'b00, 12'hA5C, 7);
    run_conv(3'd1, 1'b0, 1'b1, 2'b01, 12'h123, 7);
    run_conv(3'd7, 1'b1, 1'b1, 2'b00, 12'hFFF, 7);
    run_conv(3'd0, 1'b0, 1'b0, 2'b00, 12'h000, 7);
    run_conv(3'd6, 1'b0, 1'b1, 2'b00, 12'h800, 7);
    run_conv(3'd2, 1'b0, 1'b0, 2'b00, 12'h001, 7);

    // R7 standby, then R10 and R9 wake
    run_conv(3'd4, 1'b0, 1'b0, 2'b10, 12'h5A5, 7);
    pulse_ctl(1'b1, 3'd1, 1'b1, 1'b1);
    chk(th_track == 1'b0 && chan_sel == 3'd4, "R10 ignored in power-down",
        int'({th_track, chan_sel}), 4);
    pulse_bit();
    chk(en3() == 3, "R9 bit without arm", en3(), 3);
    pulse_addr();
    chk(en3() == 3, "R9 armed not yet awake", en3(), 3);
    pulse_bit();
    chk(en3() == 7, "R9 wake after bit", en3(), 7);

    // R7 full power-down, R9 stop clears arm, then wake
    run_conv(3'd5, 1'b1, 1'b0, 2'b11, 12'h3C3, 7);
    pulse_addr();
    pulse_stop();
    pulse_bit();
    chk(en3() == 1, "R9 stop clears arm", en3(), 1);
    pulse_addr();
    pulse_bit();
    chk(en3() == 7, "R9 wake from full", en3(), 7);

    // R10 control during conversion is ignored
    vin_r = 12'h777;
    pulse_ctl(1'b1, 3'd2, 1'b0, 1'b0);
    pulse_pd(2'b00);
    exp_q.push_back(12'h777);
    last_res = 12'h777;
    pulse_stop();
    repeat (5) @(negedge clk);
    pulse_ctl(1'b1, 3'd6, 1'b1, 1'b1);
    chk(th_track == 1'b0 && chan_sel == 3'd2, "R10 ignored in conversion",
        int'({th_track, chan_sel}), 2);
    repeat (LAT + 5) @(negedge clk);
    chk(result == 12'h777, "R10 conversion unaffected", int'(result), 12'h777);

    // R8 shutdown aborts mid-conversion
    vin_r = 12'h246;
    pulse_ctl(1'b1, 3'd1, 1'b0, 1'b0);
    pulse_pd(2'b00);
    pulse_stop();
    repeat (10) @(negedge clk);
    shdn_n = 1'b0;
    #1;
    chk(en3() == 1 && !th_track, "R8 immediate shutdown", en3(), 1);
    pulse_ctl(1'b1, 3'd3, 1'b0, 1'b0);
    chk(th_track == 1'b0, "R8 no acquisition in shutdown", int'(th_track), 0);
    repeat (LAT + 10) @(negedge clk);
    chk(result == last_res, "R8 aborted no result", int'(result), int'(last_res));
    shdn_n = 1'b1;
    @(negedge clk);
    chk(core_en == 1'b0, "R8 release synchronized", int'(core_en), 0);
    @(negedge clk);
    chk(en3() == 7, "R8 release after two edges", en3(), 7);

    // R11 shutdown on the last decision edge
    vin_r = 12'h9AB;
    pulse_ctl(1'b1, 3'd0, 1'b0, 1'b0);
    pulse_pd(2'b10);
    pulse_stop();
    repeat (LAT - 1) @(negedge clk);
    shdn_n = 1'b0;
    repeat (4) @(negedge clk);
    chk(result == last_res, "R11 no result on coincident shutdown",
        int'(result), int'(last_res));
    shdn_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(en3() == 7, "R11 pending mode not applied", en3(), 7);
    run_conv(3'd3, 1'b0, 1'b0, 2'b00, 12'h9AB, 7);
    chk(result == 12'h9AB, "R11 next conversion", int'(result), 12'h9AB);

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R5 all results delivered", exp_q.size(), 0);
    finish_run();
  end
endmodule